// File: doc/BRIEF.md
# Serial Equalizer Control Register Receiver

This block takes control words for a stereo, four-band parametric equalizer over a three-wire serial link: a frame-enable line, a shift clock and a data line. It runs on a fast system clock that oversamples all three pins. While the enable line is high, the block shifts in one bit on each rising shift-clock edge. When the enable line falls, it checks the captured frame. The frame must have exactly the right length, the expected address and legal field values. Only a frame that passes all checks is written to the setting registers.

For each channel (left, right) and each band (low, low-mid, high-mid, high), the block holds a center-frequency index, a gain index and a Q index. Each channel also has a low-band shelving flag. One global flag doubles the center frequency of every band. The registered codes leave the block as flat vectors that drive the switch network of the analog filters. The block contains no filtering itself.

Top module: `eq_ctrl_rx`

## Requirements
- R1: A frame holds exactly 28 bits, and the first bit received is frame bit 0. Bits 0..7 form the address (bit 0 is the address LSB). Bits 8..27 are data bits D0..D19. If any other number of bits was shifted when the enable line falls, the frame is dropped and every output keeps its value.
- R2: A bit is taken only on a rising edge of the shift clock while the enable line is high. Shift-clock edges while the enable line is low have no effect. Outputs never change except in response to a fall of the enable line.
- R3: A frame whose address differs from the parameter `ADDR_CODE` (default 8'hA5) is dropped.
- R4: The frequency index sits in D9..D12. Values 0..10 are accepted. A value above 10 drops the frame.
- R5: The gain index sits in D13..D16. Values 0..12 are accepted, and 6 means 0 dB. A value above 12 drops the frame.
- R6: The channel select sits in D4..D5. The codes are 01 for left only, 10 for right only and 11 for both channels, so one frame can write both channels with the same data.
- R7: The band code sits in D6..D8. The codes are 000 for low (peaking), 001 for low-mid, 010 for high-mid, 011 for high and 100 for low (shelving). Codes 101..111 drop the frame.
- R8: Band codes 000 and 100 both write the low band's settings. Code 000 clears the channel's shelving flag and code 100 sets it. The other band codes leave the flag unchanged.
- R9: Bit D3 is the frequency-doubling flag, and every accepted frame stores it. When D4..D5 are 00, only the doubling flag is stored. All other data bits are then ignored, even if they hold out-of-range values.
- R10: After reset, every band has gain index 6, frequency index 0 and Q index 0. The shelving flags and the doubling flag are 0.
- R11: The Q index sits in D0..D2 and is written to the selected band together with the frequency and gain. Bits D17..D19 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_pin | input | 1 | Frame enable line (asynchronous) |
| sclk_pin | input | 1 | Serial shift clock (asynchronous) |
| sdi_pin | input | 1 | Serial data (asynchronous) |
| freq_o | output | 32 | Frequency index per band; field (ch*4+band)*4, ch 0 = left, band 0 = low |
| gain_o | output | 32 | Gain index per band, same packing |
| q_o | output | 24 | Q index per band; field (ch*4+band)*3 |
| shelf_o | output | 2 | Low-band shelving flag, bit 0 = left |
| dbl_o | output | 1 | Global frequency-doubling flag |

## Verification
The hardest case to reach from the ports is an enable-line fall whose frame is well formed but still has to be rejected or only partly applied. Examples are a bit count one above or below 28, a field exactly one step past its limit, and a doubling-only frame that also carries illegal band data. The directed tasks build each such frame bit by bit. Before the frame ends, they check that the outputs still match the last accepted state. Shift-clock pulses sent while the enable line is low are mixed in ahead of a valid frame to confirm they are not counted.

// File: rtl/eqrx_pkg.sv
package eqrx_pkg;
    localparam int NCH       = 2;
    localparam int NBAND     = 4;
    localparam int FREQ_W    = 4;
    localparam int GAIN_W    = 4;
    localparam int Q_W       = 3;
    localparam int ADDR_W    = 8;
    localparam int DATA_W    = 20;
    localparam int FRAME_W   = ADDR_W + DATA_W;
    localparam int CNT_W     = $clog2(FRAME_W + 2);
    localparam int BAND_W    = $clog2(NBAND);
    localparam int FREQ_MAX  = 10;
    localparam int GAIN_MAX  = 12;
    localparam int GAIN_FLAT = 6;

    // data field positions, relative to D0
    localparam int POS_Q    = 0;
    localparam int POS_DBL  = POS_Q + Q_W;
    localparam int POS_CH   = POS_DBL + 1;
    localparam int POS_BAND = POS_CH + NCH;
    localparam int POS_FREQ = POS_BAND + 3;
    localparam int POS_GAIN = POS_FREQ + FREQ_W;

    typedef enum logic [2:0] {
        SEL_LOW_PEAK  = 3'd0,
        SEL_LOW_MID   = 3'd1,
        SEL_HIGH_MID  = 3'd2,
        SEL_HIGH      = 3'd3,
        SEL_LOW_SHELF = 3'd4
    } band_sel_e;

    typedef struct packed {
        logic [FREQ_W-1:0] freq;
        logic [GAIN_W-1:0] gain;
        logic [Q_W-1:0]    q;
    } band_cfg_t;

    typedef struct packed {
        logic              accept;
        logic              dbl_only;
        logic              dbl;
        logic [NCH-1:0]    ch_mask;
        logic [BAND_W-1:0] band_idx;
        logic              shelf_wr;
        logic              shelf_val;
        band_cfg_t         cfg;
    } cmd_t;
endpackage

// File: rtl/eqrx_sync.sv
module eqrx_sync #(
    parameter int STAGES = 2,
    parameter int WIDTH  = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] level_o,
    output logic [WIDTH-1:0] rise_o,
    output logic [WIDTH-1:0] fall_o
);
    logic [WIDTH-1:0] sync_d [STAGES];
    logic [WIDTH-1:0] sync_q [STAGES];
    logic [WIDTH-1:0] prev_d, prev_q;

    always_comb begin
        sync_d[0] = async_i;
        for (int s = 1; s < STAGES; s++) sync_d[s] = sync_q[s-1];
        prev_d = sync_q[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) sync_q[s] <= '0;
            prev_q <= '0;
        end else begin
            for (int s = 0; s < STAGES; s++) sync_q[s] <= sync_d[s];
            prev_q <= prev_d;
        end
    end

    assign level_o = sync_q[STAGES-1];
    assign rise_o  = sync_q[STAGES-1] & ~prev_q;
    assign fall_o  = ~sync_q[STAGES-1] & prev_q;
endmodule

// File: rtl/eqrx_shift.sv
module eqrx_shift
    import eqrx_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ce_lvl,
    input  logic               ce_rise,
    input  logic               sclk_rise,
    input  logic               sdi_lvl,
    output logic [FRAME_W-1:0] frame_o,
    output logic [CNT_W-1:0]   cnt_o
);
    localparam logic [CNT_W-1:0] CNT_SAT = CNT_W'(FRAME_W + 1);

    typedef struct packed {
        logic [FRAME_W-1:0] sr;
        logic [CNT_W-1:0]   cnt;
    } shift_st_t;

    shift_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (ce_rise) begin
            st_d.cnt = '0;
        end else if (ce_lvl && sclk_rise) begin
            // first bit ends up at index 0 after a full frame
            st_d.sr = {sdi_lvl, st_q.sr[FRAME_W-1:1]};
            if (st_q.cnt != CNT_SAT) st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign frame_o = st_q.sr;
    assign cnt_o   = st_q.cnt;
endmodule

// File: rtl/eqrx_decode.sv
module eqrx_decode
    import eqrx_pkg::*;
#(
    parameter logic [ADDR_W-1:0] ADDR_CODE = 8'hA5
) (
    input  logic [FRAME_W-1:0] frame_i,
    input  logic [CNT_W-1:0]   cnt_i,
    output cmd_t               cmd_o
);
    logic [DATA_W-1:0] dat;
    logic [2:0]        sel;
    logic              frame_ok, band_ok, range_ok;

    always_comb begin
        dat      = frame_i[FRAME_W-1:ADDR_W];
        sel      = dat[POS_BAND +: 3];
        frame_ok = (cnt_i == CNT_W'(FRAME_W)) && (frame_i[ADDR_W-1:0] == ADDR_CODE);
        band_ok  = (sel <= 3'(SEL_LOW_SHELF));
        range_ok = (dat[POS_FREQ +: FREQ_W] <= FREQ_W'(FREQ_MAX)) &&
                   (dat[POS_GAIN +: GAIN_W] <= GAIN_W'(GAIN_MAX));

        cmd_o           = '0;
        cmd_o.dbl       = dat[POS_DBL];
        cmd_o.ch_mask   = dat[POS_CH +: NCH];
        cmd_o.dbl_only  = (dat[POS_CH +: NCH] == '0);
        cmd_o.accept    = frame_ok && (cmd_o.dbl_only || (band_ok && range_ok));
        cmd_o.band_idx  = (sel == 3'(SEL_LOW_SHELF)) ? '0 : sel[BAND_W-1:0];
        cmd_o.shelf_wr  = (sel == 3'(SEL_LOW_PEAK)) || (sel == 3'(SEL_LOW_SHELF));
        cmd_o.shelf_val = (sel == 3'(SEL_LOW_SHELF));
        cmd_o.cfg.freq  = dat[POS_FREQ +: FREQ_W];
        cmd_o.cfg.gain  = dat[POS_GAIN +: GAIN_W];
        cmd_o.cfg.q     = dat[POS_Q +: Q_W];
    end
endmodule

// File: rtl/eq_ctrl_rx.sv
module eq_ctrl_rx
    import eqrx_pkg::*;
#(
    parameter logic [ADDR_W-1:0] ADDR_CODE   = 8'hA5,
    parameter int                SYNC_STAGES = 2
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          ce_pin,
    input  logic                          sclk_pin,
    input  logic                          sdi_pin,
    output logic [NCH*NBAND*FREQ_W-1:0]   freq_o,
    output logic [NCH*NBAND*GAIN_W-1:0]   gain_o,
    output logic [NCH*NBAND*Q_W-1:0]      q_o,
    output logic [NCH-1:0]                shelf_o,
    output logic                          dbl_o
);
    localparam int PIN_CE = 0;
    localparam int PIN_CK = 1;
    localparam int PIN_DI = 2;

    typedef struct packed {
        band_cfg_t [NCH-1:0][NBAND-1:0] cfg;
        logic [NCH-1:0]                 shelf;
        logic                           dbl;
    } set_st_t;

    function automatic set_st_t flat_state();
        set_st_t s;
        s = '0;
        for (int c = 0; c < NCH; c++)
            for (int b = 0; b < NBAND; b++)
                s.cfg[c][b].gain = GAIN_W'(GAIN_FLAT);
        return s;
    endfunction

    logic [2:0]         pin_lvl, pin_rise, pin_fall;
    logic               ce_fall;
    logic [FRAME_W-1:0] frame;
    logic [CNT_W-1:0]   bit_cnt;
    cmd_t               cmd;
    set_st_t            st_d, st_q;

    eqrx_sync #(.STAGES(SYNC_STAGES), .WIDTH(3)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({sdi_pin, sclk_pin, ce_pin}),
        .level_o (pin_lvl),
        .rise_o  (pin_rise),
        .fall_o  (pin_fall)
    );

    assign ce_fall = pin_fall[PIN_CE];

    eqrx_shift u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .ce_lvl    (pin_lvl[PIN_CE]),
        .ce_rise   (pin_rise[PIN_CE]),
        .sclk_rise (pin_rise[PIN_CK]),
        .sdi_lvl   (pin_lvl[PIN_DI]),
        .frame_o   (frame),
        .cnt_o     (bit_cnt)
    );

    eqrx_decode #(.ADDR_CODE(ADDR_CODE)) u_dec (
        .frame_i (frame),
        .cnt_i   (bit_cnt),
        .cmd_o   (cmd)
    );

    always_comb begin
        st_d = st_q;
        if (ce_fall && cmd.accept) begin
            st_d.dbl = cmd.dbl;
            if (!cmd.dbl_only) begin
                for (int c = 0; c < NCH; c++) begin
                    if (cmd.ch_mask[c]) begin
                        st_d.cfg[c][cmd.band_idx] = cmd.cfg;
                        if (cmd.shelf_wr) st_d.shelf[c] = cmd.shelf_val;
                    end
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= flat_state();
        else        st_q <= st_d;
    end

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        for (genvar b = 0; b < NBAND; b++) begin : g_band
            localparam int IDX = c * NBAND + b;
            assign freq_o[IDX*FREQ_W +: FREQ_W] = st_q.cfg[c][b].freq;
            assign gain_o[IDX*GAIN_W +: GAIN_W] = st_q.cfg[c][b].gain;
            assign q_o[IDX*Q_W +: Q_W]          = st_q.cfg[c][b].q;
        end
    end

    assign shelf_o = st_q.shelf;
    assign dbl_o   = st_q.dbl;
endmodule

// File: rtl/eqrx_chk.sv
module eqrx_chk
    import eqrx_pkg::*;
(
    input logic                        clk,
    input logic                        rst_n,
    input logic                        ce_fall,
    input logic [CNT_W-1:0]            bit_cnt,
    input logic [NCH*NBAND*FREQ_W-1:0] freq_o,
    input logic [NCH*NBAND*GAIN_W-1:0] gain_o,
    input logic [NCH*NBAND*Q_W-1:0]    q_o,
    input logic [NCH-1:0]              shelf_o,
    input logic                        dbl_o
);
    AST_FREQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !ce_fall |=> $stable(freq_o)); // R2
    AST_GAIN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !ce_fall |=> $stable(gain_o)); // R2
    AST_Q_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !ce_fall |=> $stable(q_o)); // R11
    AST_SHELF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !ce_fall |=> $stable(shelf_o)); // R8
    AST_DBL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !ce_fall |=> $stable(dbl_o)); // R9
    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        bit_cnt <= CNT_W'(FRAME_W + 1)); // R1

    always_ff @(posedge clk) begin
        if (rst_n) begin
            for (int i = 0; i < NCH * NBAND; i++) begin
                AST_FREQ_LIMIT: assert (freq_o[i*FREQ_W +: FREQ_W] <= FREQ_W'(FREQ_MAX)); // R4
                AST_GAIN_LIMIT: assert (gain_o[i*GAIN_W +: GAIN_W] <= GAIN_W'(GAIN_MAX)); // R5
            end
        end
    end
endmodule

bind eq_ctrl_rx eqrx_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .ce_fall (ce_fall),
    .bit_cnt (bit_cnt),
    .freq_o  (freq_o),
    .gain_o  (gain_o),
    .q_o     (q_o),
    .shelf_o (shelf_o),
    .dbl_o   (dbl_o)
);

// File: tb/eq_ctrl_rx_test.sv
module eq_ctrl_rx_test;
    localparam logic [7:0] ADDR = 8'hA5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ce_pin = 1'b0, sclk_pin = 1'b0, sdi_pin = 1'b0;
    logic [31:0] freq_o, gain_o;
    logic [23:0] q_o;
    logic [1:0]  shelf_o;
    logic        dbl_o;

    int checks = 0;
    int fails  = 0;

    logic [3:0] e_freq [2][4];
    logic [3:0] e_gain [2][4];
    logic [2:0] e_q    [2][4];
    logic [1:0] e_shelf;
    logic       e_dbl;

    always #4 clk = ~clk;

    eq_ctrl_rx uut (
        .clk(clk), .rst_n(rst_n), .ce_pin(ce_pin), .sclk_pin(sclk_pin),
        .sdi_pin(sdi_pin), .freq_o(freq_o), .gain_o(gain_o), .q_o(q_o),
        .shelf_o(shelf_o), .dbl_o(dbl_o)
    );

    function automatic logic [19:0] mk(input logic [2:0] q, input logic dbl,
                                       input logic [1:0] ch, input logic [2:0] band,
                                       input logic [3:0] freq, input logic [3:0] gain);
        return {3'b000, gain, freq, band, ch, dbl, q};
    endfunction

    task automatic model(input logic [7:0] a, input logic [19:0] d, input int nbits);
        int b;
        if (nbits != 28 || a != ADDR) return;
        if (d[5:4] == 2'b00) begin e_dbl = d[3]; return; end
        if (d[8:6] > 3'd4 || d[12:9] > 4'd10 || d[16:13] > 4'd12) return;
        e_dbl = d[3];
        b = (d[8:6] == 3'd4) ? 0 : int'(d[8:6]);
        for (int c = 0; c < 2; c++) begin
            if (d[4 + c]) begin
                e_freq[c][b] = d[12:9];
                e_gain[c][b] = d[16:13];
                e_q[c][b]    = d[2:0];
                if (d[8:6] == 3'd0) e_shelf[c] = 1'b0;
                if (d[8:6] == 3'd4) e_shelf[c] = 1'b1;
            end
        end
    endtask

    task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s act=%0h exp=%0h", tag, what, act, exp);
        end
    endtask

    task automatic check_all(input string tag);
        logic [31:0] pf, pg;
        logic [23:0] pq;
        for (int c = 0; c < 2; c++)
            for (int b = 0; b < 4; b++) begin
                pf[(c*4+b)*4 +: 4] = e_freq[c][b];
                pg[(c*4+b)*4 +: 4] = e_gain[c][b];
                pq[(c*4+b)*3 +: 3] = e_q[c][b];
            end
        chk(tag, "freq", freq_o, pf);
        chk(tag, "gain", gain_o, pg);
        chk(tag, "q", {8'h0, q_o}, {8'h0, pq});
        chk(tag, "shelf", {30'h0, shelf_o}, {30'h0, e_shelf});
        chk(tag, "dbl", {31'h0, dbl_o}, {31'h0, e_dbl});
    endtask

    task automatic wclk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic shift_bits(input logic [27:0] f, input int nbits);
        for (int k = 0; k < nbits; k++) begin
            sdi_pin = (k < 28) ? f[k] : 1'b0;
            wclk(6);
            sclk_pin = 1'b1;
            wclk(6);
            sclk_pin = 1'b0;
        end
    endtask

    task automatic send(input logic [7:0] a, input logic [19:0] d, input int nbits);
        ce_pin = 1'b1;
        wclk(6);
        shift_bits({d, a}, nbits);
        wclk(6);
        ce_pin = 1'b0;
        wclk(10);
        model(a, d, nbits);
    endtask

    task automatic t_reset();
        for (int c = 0; c < 2; c++)
            for (int b = 0; b < 4; b++) begin
                e_freq[c][b] = 4'd0; e_gain[c][b] = 4'd6; e_q[c][b] = 3'd0;
            end
        e_shelf = 2'b00; e_dbl = 1'b0;
        check_all("R10");
    endtask

    task automatic t_left_basic();
        send(ADDR, mk(3'd5, 1'b0, 2'b01, 3'd1, 4'd7, 4'd9), 28);
        check_all("R6_left R11");
        send(ADDR, mk(3'd2, 1'b0, 2'b01, 3'd3, 4'd3, 4'd1) | 20'hE0000, 28);
        check_all("R11 reserved");
    endtask

    task automatic t_right_both();
        send(ADDR, mk(3'd7, 1'b0, 2'b10, 3'd2, 4'd4, 4'd11), 28);
        check_all("R6_right");
        send(ADDR, mk(3'd1, 1'b0, 2'b11, 3'd3, 4'd9, 4'd2), 28);
        check_all("R6_both");
    endtask

    task automatic t_bands();
        for (int b = 0; b < 4; b++) begin
            send(ADDR, mk(3'(b+1), 1'b0, 2'b11, 3'(b), 4'(b+2), 4'(b+3)), 28);
            check_all("R7");
        end
        send(ADDR, mk(3'd6, 1'b0, 2'b11, 3'd5, 4'd1, 4'd1), 28);
        check_all("R7_bad_code");
        send(ADDR, mk(3'd6, 1'b0, 2'b11, 3'd7, 4'd1, 4'd1), 28);
        check_all("R7_bad_code");
    endtask

    task automatic t_shelf();
        send(ADDR, mk(3'd3, 1'b0, 2'b01, 3'd4, 4'd10, 4'd12), 28);
        check_all("R8_set");
        send(ADDR, mk(3'd3, 1'b0, 2'b11, 3'd2, 4'd5, 4'd5), 28);
        check_all("R8_other_band");
        send(ADDR, mk(3'd0, 1'b0, 2'b11, 3'd4, 4'd0, 4'd0), 28);
        check_all("R8_both");
        send(ADDR, mk(3'd4, 1'b0, 2'b10, 3'd0, 4'd8, 4'd6), 28);
        check_all("R8_clear");
    endtask

    task automatic t_addr();
        send(ADDR ^ 8'h01, mk(3'd1, 1'b1, 2'b11, 3'd1, 4'd1, 4'd1), 28);
        check_all("R3");
        send(ADDR ^ 8'h80, mk(3'd1, 1'b1, 2'b11, 3'd1, 4'd1, 4'd1), 28);
        check_all("R3");
    endtask

    task automatic t_length();
        send(ADDR, mk(3'd6, 1'b1, 2'b11, 3'd3, 4'd6, 4'd6), 27);
        check_all("R1_short");
        send(ADDR, mk(3'd6, 1'b1, 2'b11, 3'd3, 4'd6, 4'd6), 29);
        check_all("R1_long");
        send(ADDR, mk(3'd6, 1'b0, 2'b11, 3'd3, 4'd6, 4'd6), 28);
        check_all("R1_exact");
    endtask

    task automatic t_range();
        send(ADDR, mk(3'd2, 1'b0, 2'b01, 3'd1, 4'd11, 4'd4), 28);
        check_all("R4_over");
        send(ADDR, mk(3'd2, 1'b0, 2'b01, 3'd1, 4'd10, 4'd4), 28);
        check_all("R4_max");
        send(ADDR, mk(3'd2, 1'b0, 2'b10, 3'd1, 4'd3, 4'd13), 28);
        check_all("R5_over");
        send(ADDR, mk(3'd2, 1'b0, 2'b10, 3'd1, 4'd3, 4'd12), 28);
        check_all("R5_max");
        send(ADDR, mk(3'd2, 1'b0, 2'b10, 3'd1, 4'd3, 4'd0), 28);
        check_all("R5_min");
    endtask

    task automatic t_double();
        send(ADDR, mk(3'd7, 1'b1, 2'b00, 3'd7, 4'd15, 4'd15), 28);
        check_all("R9_only");
        send(ADDR, mk(3'd1, 1'b0, 2'b01, 3'd2, 4'd2, 4'd8), 28);
        check_all("R9_clear_with_band");
        send(ADDR, mk(3'd1, 1'b1, 2'b10, 3'd3, 4'd1, 4'd7), 28);
        check_all("R9_set_with_band");
    endtask

    task automatic t_gating();
        // shift clocks with enable low must not count
        for (int k = 0; k < 5; k++) begin
            sdi_pin = 1'b1; wclk(6); sclk_pin = 1'b1; wclk(6); sclk_pin = 1'b0;
        end
        wclk(6);
        check_all("R2_idle_clocks");
        ce_pin = 1'b1;
        wclk(6);
        shift_bits({mk(3'd5, 1'b0, 2'b11, 3'd0, 4'd9, 4'd10), ADDR}, 28);
        wclk(20);
        check_all("R2_before_fall");
        ce_pin = 1'b0;
        wclk(10);
        model(ADDR, mk(3'd5, 1'b0, 2'b11, 3'd0, 4'd9, 4'd10), 28);
        check_all("R2_after_fall");
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog act=running exp=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        wclk(5);
        rst_n = 1'b1;
        wclk(5);
        t_reset();
        t_left_basic();
        t_right_both();
        t_bands();
        t_shelf();
        t_addr();
        t_length();
        t_range();
        t_double();
        t_gating();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule